// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is one general-purpose I/O port of up to sixteen pins behind a word-wide register interface. Each pin has an output latch and a direction bit, which together drive the pad, and a synchronized copy of the pad level that software can read. Each pin also has its own event detector. The detector can fire on a rising edge, a falling edge, either edge, a high level or a low level.

Detector hits set pending bits when the pin's enable allows it. Software clears pending bits by writing ones to a separate clear word. A mask, set and cleared through a pair of write-one words, hides pending bits from the combined interrupt line without discarding them. A software-reset word returns every register to its default while its bit is held at one.

Register access is plain and single-cycle, with no handshake. A write takes effect on the clock edge where `reg_we` is high. Read data is combinational from `reg_addr`. Data-flow handshakes are not used because every access completes in one cycle.

Top module: `gpio_irq_port`

## Requirements
- R1: The word map (word index on `reg_addr`) is: 0 enable, 1 pending status, 2 visible pending, 3 clear, 4 mask-set, 5 mask-clear, 6 output latch, 7 input, 8 direction, 9 mode word A, 10 mode word B, 11 reserved, 12 software reset (bit 0). After `rst_n` every word reads 0, `pin_oe` and `pin_out` are 0 and `irq` is 0.
- R2: `pin_oe` equals the direction word and `pin_out` equals the output latch. A direction bit of 1 makes that pin an output. Both words read back what was written.
- R3: The input word returns the pad levels through a two-flop synchronizer. A pad change made before a clock edge is visible from the second edge on, and not after the first.
- R4: The mode code of pin i sits in bits [4*(i mod 8)+2 : 4*(i mod 8)] of mode word A for pins 0-7 and of mode word B for pins 8-15. Bit 3 of each nibble is not stored and reads 0. The codes are: 0 falling edge, 1 rising edge, 2 low level, 3 high level, 4 both edges.
- R5: An edge is a difference between the synchronized level and its value one cycle earlier. A matching pad edge on an enabled pin sets the pending bit at the third clock edge after the pad changes.
- R6: In a level mode, the pending bit is set on every cycle the level holds while the pin is enabled. If a clear is written in such a cycle, the set wins.
- R7: A pin whose enable bit is 0 never sets its pending bit.
- R8: Writing 1 to a bit of the clear word clears that pending bit. Zero bits, and writes to the pending-status word, leave pending bits unchanged.
- R9: Writing 1 to a bit of the mask-set word masks that pin, and writing 1 to the mask-clear word unmasks it. The visible-pending word is pending AND NOT mask, and `irq` is the OR of the visible bits. Masking leaves the pending bits intact.
- R10: While the software-reset bit is 1, all other registers are held at their reset values. Writing 1 and then 0 leaves the port in its reset state.
- R11: Mode codes 5, 6 and 7 never detect. The reserved word reads 0 whatever is written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Write strobe for the addressed word |
| reg_addr | input | 4 | Word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data of the addressed word (combinational) |
| pin_in | input | PINS | Pad input levels (asynchronous) |
| pin_out | output | PINS | Output latch toward the pads |
| pin_oe | output | PINS | Per-pin output enable (direction) |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The input word follows a pad change at the second rising edge. An edge or level hit shows in the pending word at the third edge. Register writes show at the first edge after the strobe. The visible-pending word and `irq` follow pending and mask with no added delay. The bench changes pads and strobes on falling edges. It then waits exactly two, three or four falling edges, or more where only the settled value matters, and samples half a period away from any active edge. For the level-hold case, the bench reads the pending word on the same falling edge that ends the clear write, so the re-set is caught in the cycle it happens.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int REG_AW = 4;
  localparam int DW     = 32;

  localparam logic [REG_AW-1:0] A_EN    = 4'd0;
  localparam logic [REG_AW-1:0] A_STAT  = 4'd1;
  localparam logic [REG_AW-1:0] A_VIS   = 4'd2;
  localparam logic [REG_AW-1:0] A_CLR   = 4'd3;
  localparam logic [REG_AW-1:0] A_MSET  = 4'd4;
  localparam logic [REG_AW-1:0] A_MCLR  = 4'd5;
  localparam logic [REG_AW-1:0] A_OUT   = 4'd6;
  localparam logic [REG_AW-1:0] A_IN    = 4'd7;
  localparam logic [REG_AW-1:0] A_DIR   = 4'd8;
  localparam logic [REG_AW-1:0] A_MODE0 = 4'd9;
  localparam logic [REG_AW-1:0] A_RSVD  = 4'd11;
  localparam logic [REG_AW-1:0] A_SRST  = 4'd12;

  localparam logic [2:0] M_FALL   = 3'd0;
  localparam logic [2:0] M_RISE   = 3'd1;
  localparam logic [2:0] M_LVL_LO = 3'd2;
  localparam logic [2:0] M_LVL_HI = 3'd3;
  localparam logic [2:0] M_BOTH   = 3'd4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_i;
      stage2_q <= stage1_q;
    end
  end

  assign sync_o = stage2_q;
endmodule

// File: rtl/gpio_pin_det.sv
module gpio_pin_det
  import gpio_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       level_i,
  input  logic       en_i,
  input  logic [2:0] mode_i,
  output logic       hit_o
);
  logic prev_q;
  logic cond;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= level_i;
  end

  always_comb begin
    case (mode_i)
      M_FALL:   cond = prev_q & ~level_i;
      M_RISE:   cond = ~prev_q & level_i;
      M_LVL_LO: cond = ~level_i;
      M_LVL_HI: cond = level_i;
      M_BOTH:   cond = prev_q ^ level_i;
      default:  cond = 1'b0;
    endcase
  end

  assign hit_o = en_i & cond;

  // R7: a disabled detector never reports a hit
  p_no_hit_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> !hit_o);
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_pkg::*;
#(
  parameter int PINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  output logic              irq
);
  localparam int PPW = 8;  // pins per mode word

  logic [PINS-1:0] en_q, status_q, mask_q, out_q, dir_q;
  logic [2:0]      mode_q [PINS];
  logic            srst_q;
  logic [PINS-1:0] lvl_sync, hit, vis;

  logic wr_en, wr_clr, wr_mset, wr_mclr, wr_out, wr_dir, wr_srst;
  assign wr_en   = reg_we && reg_addr == A_EN;
  assign wr_clr  = reg_we && reg_addr == A_CLR;
  assign wr_mset = reg_we && reg_addr == A_MSET;
  assign wr_mclr = reg_we && reg_addr == A_MCLR;
  assign wr_out  = reg_we && reg_addr == A_OUT;
  assign wr_dir  = reg_we && reg_addr == A_DIR;
  assign wr_srst = reg_we && reg_addr == A_SRST;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata;

  gpio_sync #(.W(PINS)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_in), .sync_o(lvl_sync)
  );

  for (genvar g = 0; g < PINS; g++) begin : g_pin
    gpio_pin_det u_det (
      .clk(clk), .rst_n(rst_n), .level_i(lvl_sync[g]), .en_i(en_q[g]),
      .mode_i(mode_q[g]), .hit_o(hit[g])
    );

    // R8: a written clear with no simultaneous hit drops the pending bit
    p_clear_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_clr && reg_wdata[g] && !hit[g]) |=> !status_q[g]);
    // R7: a disabled, idle pin stays idle
    p_enable_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q[g] && !status_q[g]) |=> !status_q[g]);
    // R6: a held high level re-sets pending each cycle
    p_level_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q[g] && mode_q[g] == M_LVL_HI && lvl_sync[g] && !srst_q) |=> status_q[g]);
    // R9: mask-set write masks the pin
    p_mask_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mset && reg_wdata[g] && !srst_q) |=> mask_q[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) srst_q <= 1'b0;
    else if (wr_srst) srst_q <= reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0; status_q <= '0; mask_q <= '0; out_q <= '0; dir_q <= '0;
      for (int i = 0; i < PINS; i++) mode_q[i] <= M_FALL;
    end else if (srst_q) begin
      en_q <= '0; status_q <= '0; mask_q <= '0; out_q <= '0; dir_q <= '0;
      for (int i = 0; i < PINS; i++) mode_q[i] <= M_FALL;
    end else begin
      if (wr_en)  en_q  <= reg_wdata[PINS-1:0];
      if (wr_out) out_q <= reg_wdata[PINS-1:0];
      if (wr_dir) dir_q <= reg_wdata[PINS-1:0];
      if (wr_mset)      mask_q <= mask_q | reg_wdata[PINS-1:0];
      else if (wr_mclr) mask_q <= mask_q & ~reg_wdata[PINS-1:0];
      status_q <= (status_q & ~(wr_clr ? reg_wdata[PINS-1:0] : '0)) | hit;
      for (int i = 0; i < PINS; i++)
        if (reg_we && reg_addr == REG_AW'(int'(A_MODE0) + i / PPW))
          mode_q[i] <= reg_wdata[4*(i%PPW) +: 3];
    end
  end

  assign vis     = status_q & ~mask_q;
  assign irq     = |vis;
  assign pin_out = out_q;
  assign pin_oe  = dir_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_EN:    reg_rdata[PINS-1:0] = en_q;
      A_STAT:  reg_rdata[PINS-1:0] = status_q;
      A_VIS:   reg_rdata[PINS-1:0] = vis;
      A_MSET:  reg_rdata[PINS-1:0] = mask_q;
      A_OUT:   reg_rdata[PINS-1:0] = out_q;
      A_IN:    reg_rdata[PINS-1:0] = lvl_sync;
      A_DIR:   reg_rdata[PINS-1:0] = dir_q;
      A_SRST:  reg_rdata[0]        = srst_q;
      default: reg_rdata = '0;
    endcase
    for (int i = 0; i < PINS; i++)
      if (reg_addr == REG_AW'(int'(A_MODE0) + i / PPW))
        reg_rdata[4*(i%PPW) +: 3] = mode_q[i];
  end

  // R10: while soft reset is held the configuration clears next cycle
  p_srst_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (en_q == '0 && status_q == '0 && mask_q == '0 && dir_q == '0 && out_q == '0));
  // R9: the line is only raised by some pending bit
  p_irq_needs_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status_q != '0);
endmodule

// File: tb/tb_gpio_irq_port.sv
`timescale 1ns/1ps
module tb_gpio_irq_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic        irq;
  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  gpio_irq_port dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  // {mode[2:0], initial level, final level, expected pending}
  localparam logic [5:0] VEC [12] = '{
    {3'd0, 1'b1, 1'b0, 1'b1}, {3'd0, 1'b0, 1'b1, 1'b0},
    {3'd1, 1'b0, 1'b1, 1'b1}, {3'd1, 1'b1, 1'b0, 1'b0},
    {3'd4, 1'b0, 1'b1, 1'b1}, {3'd4, 1'b1, 1'b0, 1'b1},
    {3'd2, 1'b1, 1'b1, 1'b0}, {3'd2, 1'b1, 1'b0, 1'b1},
    {3'd3, 1'b0, 1'b1, 1'b1}, {3'd3, 1'b0, 1'b0, 1'b0},
    {3'd5, 1'b0, 1'b1, 1'b0}, {3'd7, 1'b1, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #2000000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(1);

    // R1: reset state of every word
    for (int a = 0; a <= 12; a++) begin
      rd(4'(a), v);
      chk("R1 reset word", v, 32'h0);
    end
    chk("R1 reset pins", {pin_oe, pin_out}, 32'h0);
    chk("R1 reset irq", {31'h0, irq}, 32'h0);

    // R2: direction and output latch
    wr(4'd8, 32'h0000_00F0);
    wr(4'd6, 32'h0000_0050);
    chk("R2 pin_oe", {16'h0, pin_oe}, 32'h0000_00F0);
    chk("R2 pin_out", {16'h0, pin_out}, 32'h0000_0050);
    rd(4'd8, v); chk("R2 dir readback", v, 32'h0000_00F0);

    // R3: two-stage synchronizer latency
    @(negedge clk); pin_in = 16'hA5A5;
    wait_n(1); rd(4'd7, v); chk("R3 input after 1 edge", v, 32'h0);
    wait_n(1); rd(4'd7, v); chk("R3 input after 2 edges", v, 32'h0000_A5A5);
    pin_in = 16'h0;
    wait_n(3);

    // R4 R5 R6 R11: vector table on pin 3
    for (int k = 0; k < 12; k++) begin
      wr(4'd0, 32'h0);
      wr(4'd9, {17'h0, VEC[k][5:3], 12'h0});
      pin_in[3] = VEC[k][2];
      wait_n(4);
      wr(4'd3, 32'h8);
      wr(4'd0, 32'h8);
      pin_in[3] = VEC[k][1];
      wait_n(4);
      rd(4'd1, v);
      chk($sformatf("R5/R6/R11 vector %0d", k), {31'h0, v[3]}, {31'h0, VEC[k][0]});
    end
    wr(4'd0, 32'h0);
    pin_in = 16'h0;
    wait_n(3);
    wr(4'd3, 32'hFFFF);

    // R4: field packing
    wr(4'd9, 32'hFFFF_FFFF);
    rd(4'd9, v); chk("R4 nibble bit3 dropped", v, 32'h7777_7777);
    wr(4'd9, 32'h0);
    wr(4'd10, 32'h0000_0010);
    rd(4'd10, v); chk("R4 pin9 in word B", v, 32'h0000_0010);

    // R5: edge timing on pin 9
    wr(4'd0, 32'h0000_0200);
    @(negedge clk); pin_in[9] = 1'b1;
    wait_n(2); rd(4'd1, v); chk("R5 not yet at 2 edges", v, 32'h0);
    wait_n(1); rd(4'd1, v); chk("R5 pending at 3 edges", v, 32'h0000_0200);
    chk("R9 irq raised", {31'h0, irq}, 32'h1);

    // R9: mask
    wr(4'd4, 32'h0000_0200);
    rd(4'd2, v); chk("R9 visible masked", v, 32'h0);
    chk("R9 irq masked", {31'h0, irq}, 32'h0);
    rd(4'd1, v); chk("R9 pending kept", v, 32'h0000_0200);
    wr(4'd5, 32'h0);
    chk("R9 zero mask-clear bits", {31'h0, irq}, 32'h0);
    wr(4'd5, 32'h0000_0200);
    rd(4'd2, v); chk("R9 visible unmasked", v, 32'h0000_0200);

    // R7: pin 10 disabled, rising mode
    wr(4'd10, 32'h0000_0110);
    pin_in[10] = 1'b1;
    wait_n(5); rd(4'd1, v); chk("R7 disabled pin quiet", v, 32'h0000_0200);

    // R8 R11: no-effect writes, then clear
    wr(4'd1, 32'h0);
    rd(4'd1, v); chk("R8 status write ignored", v, 32'h0000_0200);
    wr(4'd3, 32'h0000_0100);
    rd(4'd1, v); chk("R8 other bit clear", v, 32'h0000_0200);
    wr(4'd3, 32'h0000_0200);
    rd(4'd1, v); chk("R8 clear", v, 32'h0);
    wr(4'd11, 32'hFFFF_FFFF);
    rd(4'd11, v); chk("R11 reserved reads 0", v, 32'h0);

    // R6: high level persists through clear
    wr(4'd10, 32'h0000_0030);
    wait_n(1);
    rd(4'd1, v); chk("R6 level sets", v, 32'h0000_0200);
    wr(4'd3, 32'h0000_0200);
    rd(4'd1, v); chk("R6 set wins over clear", v, 32'h0000_0200);

    // R10: software reset
    wr(4'd12, 32'h1);
    wr(4'd12, 32'h0);
    wait_n(1);
    rd(4'd0, v);  chk("R10 enable", v, 32'h0);
    rd(4'd1, v);  chk("R10 status", v, 32'h0);
    rd(4'd10, v); chk("R10 mode B", v, 32'h0);
    rd(4'd6, v);  chk("R10 output", v, 32'h0);
    chk("R10 pins", {pin_oe, pin_out}, 32'h0);
    chk("R10 irq", {31'h0, irq}, 32'h0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule